// File: doc/BRIEF.md
# Digital Trim Wiper Controller

This block is the digital control section of a 32-position digitally trimmed resistor. A host drives it over three plain wires: an active-low select, a step strobe that acts on its falling edge, and a direction level. The block keeps a 5-bit wiper position and decodes it onto a one-hot tap-select bus. That bus drives the analog switches of a resistor ladder that lies outside this block. The position counter saturates at both ends. Stepping past the top or bottom tap leaves the wiper where it is.

The block also holds a modelled non-volatile copy of the position. When the host ends a session, the level of the step wire at that moment decides whether the live position is written to the non-volatile copy. If the wire is high, the position is kept in non-volatile memory. If it is low, the live position stays on the wiper but is not saved. A write starts a busy window whose length is a parameter. A select made while that window is open is ignored for the whole of that session. On a warm reset the counter reloads the stored value. A power-on reset sets the stored value to a parameter default. The three inputs are asynchronous and are synchronised onto the system clock, so every action appears three clock edges after the pin change.

Top module: `trim_wiper_ctrl`

## Requirements
- R1: While `por_n` is low, the stored copy is set to `NV_INIT` (default 16). While `rst_n` or `por_n` is low, `wiper_pos` loads the stored copy. After a warm reset, the position equals the value of the last store.
- R2: In an active session, each falling edge of `step` moves `wiper_pos` by one. A high `dir_up` moves it up and a low `dir_up` moves it down.
- R3: A step up at position 31 and a step down at position 0 leave the position unchanged. The counter never wraps.
- R4: `tap_sel` has exactly one bit set, and the set bit's index equals `wiper_pos`.
- R5: Falling edges of `step` while `sel_n` is high have no effect on the position.
- R6: When `sel_n` rises during an active session with `step` high, the position is written to the stored copy, and `store_busy` is high for exactly `STORE_CYCLES` clock cycles.
- R7: When `sel_n` rises during an active session with `step` low, nothing is stored, `store_busy` stays low, and the wiper keeps its live position.
- R8: A falling edge of `sel_n` seen while `store_busy` is high does not open a session. Steps and deselects in that selection have no effect, even after busy ends, until `sel_n` is raised and lowered again.
- R9: `dir_up` may change while the block is selected, and the next step follows the new level.
- R10: A `step` falling edge synchronised in the same cycle as a `sel_n` edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on it |
| por_n | input | 1 | Power-on reset, active low; sets the stored copy to its default |
| rst_n | input | 1 | Warm reset, active low; reloads the wiper from the stored copy |
| sel_n | input | 1 | Select, active low, asynchronous |
| step | input | 1 | Step strobe; the falling edge moves the wiper; its level at deselect picks store or discard |
| dir_up | input | 1 | Direction level: 1 steps up, 0 steps down |
| wiper_pos | output | 5 | Current wiper position, 0 to 31 |
| tap_sel | output | 32 | One-hot tap select; bit n is set when the wiper is at tap n |
| store_busy | output | 1 | High while a non-volatile write is in progress |

## Verification
The assertions assume that each input is held for at least two clock cycles between changes, so every transition passes through the synchroniser as one clean edge. They also assume that both resets are applied together at time zero. The bench drives pins only just after a falling clock edge and holds each level for four or more cycles. Every step pulse leaves a wide margin between the direction change and the strobe. The one deliberate exception is the coincidence case, where `sel_n` and `step` change in the same instant to land in the same synchronised cycle.

// File: rtl/trim_pkg.sv
package trim_pkg;

  // Synchronised copy of the three host wires
  typedef struct packed {
    logic sel_n;
    logic step;
    logic dir_up;
  } trim_pins_t;

  localparam int unsigned PIN_W = $bits(trim_pins_t);

  // Idle values loaded into the synchroniser during reset
  localparam trim_pins_t PINS_IDLE = '{sel_n: 1'b1, step: 1'b0, dir_up: 1'b0};

endpackage

// File: rtl/trim_in_sync.sv
module trim_in_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_any,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst_any) chain_q[g] <= RST_VAL;
          else         chain_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst_any) chain_q[g] <= RST_VAL;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/trim_step_ctrl.sv
module trim_step_ctrl (
  input  logic clk,
  input  logic rst_any,
  input  logic sel_n_s,
  input  logic step_s,
  input  logic dir_s,
  input  logic busy,
  output logic engaged,
  output logic inc_ev,
  output logic dec_ev,
  output logic store_ev
);

  logic sel_d;
  logic step_d;
  logic engaged_q;
  logic sel_fall;
  logic sel_rise;
  logic step_fall;
  logic move_ok;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      sel_d  <= 1'b1;
      step_d <= 1'b0;
    end else begin
      sel_d  <= sel_n_s;
      step_d <= step_s;
    end
  end

  assign sel_fall  = sel_d & ~sel_n_s;
  assign sel_rise  = ~sel_d & sel_n_s;
  assign step_fall = step_d & ~step_s;

  // A session opens only on a select edge seen while no write is running
  always_ff @(posedge clk) begin
    if (rst_any)                engaged_q <= 1'b0;
    else if (sel_rise)          engaged_q <= 1'b0;
    else if (sel_fall && !busy) engaged_q <= 1'b1;
  end

  assign move_ok  = step_fall & engaged_q & ~sel_n_s & ~sel_fall & ~sel_rise;
  assign inc_ev   = move_ok & dir_s;
  assign dec_ev   = move_ok & ~dir_s;
  assign store_ev = sel_rise & engaged_q & step_s;
  assign engaged  = engaged_q;

endmodule

// File: rtl/trim_pos_counter.sv
module trim_pos_counter #(
  parameter int unsigned POS_W = 5
) (
  input  logic             clk,
  input  logic             rst_any,
  input  logic [POS_W-1:0] recall,
  input  logic             inc_ev,
  input  logic             dec_ev,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst_any)                          pos_q <= recall;
    else if (inc_ev && pos_q != POS_MAX)  pos_q <= pos_q + 1'b1;
    else if (dec_ev && pos_q != POS_MIN)  pos_q <= pos_q - 1'b1;
  end

  assign pos = pos_q;

endmodule

// File: rtl/trim_nv_store.sv
module trim_nv_store #(
  parameter int unsigned POS_W        = 5,
  parameter int unsigned STORE_CYCLES = 5000000,
  parameter logic [POS_W-1:0] NV_INIT = 5'd16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_any,
  input  logic             store_ev,
  input  logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] nv_val,
  output logic             busy
);

  localparam int unsigned CNT_W = $clog2(STORE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STORE_CYCLES);

  logic [POS_W-1:0] nv_q;
  logic [CNT_W-1:0] wait_q;

  // Modelled non-volatile cell: cleared only by power-on reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        nv_q <= NV_INIT;
    else if (store_ev) nv_q <= pos;
  end

  always_ff @(posedge clk) begin
    if (rst_any)           wait_q <= '0;
    else if (store_ev)     wait_q <= CNT_LOAD;
    else if (wait_q != '0) wait_q <= wait_q - 1'b1;
  end

  assign nv_val = nv_q;
  assign busy   = (wait_q != '0);

endmodule

// File: rtl/trim_tap_decoder.sv
module trim_tap_decoder #(
  parameter int unsigned POS_W = 5,
  parameter int unsigned TAPS  = 32
) (
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap
);

  genvar t;
  generate
    for (t = 0; t < TAPS; t++) begin : g_tap
      assign tap[t] = (pos == POS_W'(t));
    end
  endgenerate

endmodule

// File: rtl/trim_wiper_ctrl.sv
module trim_wiper_ctrl
  import trim_pkg::*;
#(
  parameter int unsigned POS_W        = 5,
  parameter int unsigned STORE_CYCLES = 5000000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter logic [POS_W-1:0] NV_INIT = 5'd16,
  localparam int unsigned TAPS        = 1 << POS_W
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             step,
  input  logic             dir_up,
  output logic [POS_W-1:0] wiper_pos,
  output logic [TAPS-1:0]  tap_sel,
  output logic             store_busy
);

  logic       rst_any;
  trim_pins_t pins_raw;
  trim_pins_t pins_s;
  logic       engaged;
  logic       inc_ev;
  logic       dec_ev;
  logic       store_ev;
  logic [POS_W-1:0] nv_val;

  assign rst_any  = ~(rst_n & por_n);
  assign pins_raw = '{sel_n: sel_n, step: step, dir_up: dir_up};

  trim_in_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk     (clk),
    .rst_any (rst_any),
    .async_in(pins_raw),
    .sync_out(pins_s)
  );

  trim_step_ctrl u_ctrl (
    .clk     (clk),
    .rst_any (rst_any),
    .sel_n_s (pins_s.sel_n),
    .step_s  (pins_s.step),
    .dir_s   (pins_s.dir_up),
    .busy    (store_busy),
    .engaged (engaged),
    .inc_ev  (inc_ev),
    .dec_ev  (dec_ev),
    .store_ev(store_ev)
  );

  trim_pos_counter #(.POS_W(POS_W)) u_cnt (
    .clk    (clk),
    .rst_any(rst_any),
    .recall (nv_val),
    .inc_ev (inc_ev),
    .dec_ev (dec_ev),
    .pos    (wiper_pos)
  );

  trim_nv_store #(
    .POS_W       (POS_W),
    .STORE_CYCLES(STORE_CYCLES),
    .NV_INIT     (NV_INIT)
  ) u_nv (
    .clk     (clk),
    .por_n   (por_n),
    .rst_any (rst_any),
    .store_ev(store_ev),
    .pos     (wiper_pos),
    .nv_val  (nv_val),
    .busy    (store_busy)
  );

  trim_tap_decoder #(.POS_W(POS_W), .TAPS(TAPS)) u_dec (
    .pos(wiper_pos),
    .tap(tap_sel)
  );

endmodule

// File: rtl/trim_wiper_checker.sv
module trim_wiper_checker #(
  parameter int unsigned POS_W = 5,
  parameter int unsigned TAPS  = 32
) (
  input logic             clk,
  input logic             rst_any,
  input logic [POS_W-1:0] wiper_pos,
  input logic [TAPS-1:0]  tap_sel,
  input logic             store_busy,
  input logic             engaged,
  input logic             store_ev,
  input logic [POS_W-1:0] nv_val
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  assert_tap_onehot_R4: assert property (@(posedge clk) disable iff (rst_any)
    ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst_any)
    !$stable(wiper_pos) |->
      ({1'b0, wiper_pos} == {1'b0, $past(wiper_pos)} + 1'b1) ||
      ({1'b0, $past(wiper_pos)} == {1'b0, wiper_pos} + 1'b1));

  assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (rst_any)
    (wiper_pos == POS_MAX) |=> (wiper_pos != '0));

  assert_no_wrap_bottom_R3: assert property (@(posedge clk) disable iff (rst_any)
    (wiper_pos == '0) |=> (wiper_pos != POS_MAX));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst_any)
    !engaged |=> $stable(wiper_pos));

  assert_store_write_R6: assert property (@(posedge clk) disable iff (rst_any)
    store_ev |=> store_busy && (nv_val == $past(wiper_pos)));

  assert_nv_only_on_store_R7: assert property (@(posedge clk) disable iff (rst_any)
    !store_ev |=> $stable(nv_val));

  assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (rst_any)
    store_busy |=> $stable(wiper_pos));

  assert_busy_no_session_R8: assert property (@(posedge clk) disable iff (rst_any)
    store_busy && !engaged |=> !engaged);

endmodule

bind trim_wiper_ctrl trim_wiper_checker #(.POS_W(POS_W), .TAPS(TAPS)) u_chk (
  .clk       (clk),
  .rst_any   (rst_any),
  .wiper_pos (wiper_pos),
  .tap_sel   (tap_sel),
  .store_busy(store_busy),
  .engaged   (engaged),
  .store_ev  (store_ev),
  .nv_val    (nv_val)
);

// File: tb/test_trim_wiper_ctrl.sv
`timescale 1ns/1ps
module test_trim_wiper_ctrl;

  localparam int unsigned POS_W  = 5;
  localparam int unsigned TAPS   = 32;
  localparam int unsigned STORE  = 40;
  localparam int unsigned NVINIT = 16;

  logic clk = 1'b0;
  logic por_n, rst_n, sel_n, step, dir_up;
  logic [POS_W-1:0] wiper_pos;
  logic [TAPS-1:0]  tap_sel;
  logic store_busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  trim_wiper_ctrl #(
    .POS_W       (POS_W),
    .STORE_CYCLES(STORE),
    .NV_INIT     (5'(NVINIT))
  ) i_trim_wiper_ctrl (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .step      (step),
    .dir_up    (dir_up),
    .wiper_pos (wiper_pos),
    .tap_sel   (tap_sel),
    .store_busy(store_busy)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pos(input string req, input int exp);
    chk(req, int'(wiper_pos), exp);
    chk({req, " tap"}, int'(tap_sel == (32'd1 << exp)), 1);
  endtask

  task automatic pulse(input bit up);
    dir_up = up; cyc(4);
    step = 1'b0; cyc(4);
    step = 1'b1; cyc(4);
  endtask

  task automatic select_on;
    sel_n = 1'b0; cyc(4);
  endtask

  // ends a session with the step wire at the given level
  task automatic deselect(input bit step_lvl);
    if (!step_lvl) begin step = 1'b0; cyc(4); end
    sel_n = 1'b1; cyc(4);
    step = 1'b1; cyc(4);
  endtask

  task automatic warm_reset;
    rst_n = 1'b0; cyc(3);
    rst_n = 1'b1; cyc(2);
  endtask

  task automatic t_reset;
    por_n = 1'b0; rst_n = 1'b0; sel_n = 1'b1; step = 1'b1; dir_up = 1'b0;
    cyc(4);
    por_n = 1'b1; rst_n = 1'b1; cyc(3);
    chk_pos("R1 power-on default", NVINIT);
    chk("R4 reset onehot count", $countones(tap_sel), 1);
    chk("R6 busy at reset", int'(store_busy), 0);
  endtask

  task automatic t_unselected;
    for (int i = 0; i < 3; i++) pulse(1'b1);
    pulse(1'b0);
    chk_pos("R5 steps while deselected", NVINIT);
  endtask

  task automatic t_updown;
    select_on();
    for (int i = 0; i < 3; i++) pulse(1'b1);
    chk_pos("R2 up three", NVINIT + 3);
    pulse(1'b0); pulse(1'b0);
    chk_pos("R9 direction flipped down", NVINIT + 1);
    pulse(1'b1);
    chk_pos("R9 direction flipped up", NVINIT + 2);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 20; i++) pulse(1'b1);
    chk_pos("R3 top stop", 31);
    pulse(1'b1);
    chk_pos("R3 top again", 31);
    for (int i = 0; i < 35; i++) pulse(1'b0);
    chk_pos("R3 bottom stop", 0);
    pulse(1'b0);
    chk_pos("R3 bottom again", 0);
  endtask

  task automatic t_discard;
    for (int i = 0; i < 5; i++) pulse(1'b1);
    dir_up = 1'b1; cyc(4);
    deselect(1'b0);
    chk_pos("R7 discard keeps live position", 6);
    chk("R7 no busy on discard", int'(store_busy), 0);
  endtask

  task automatic t_store_and_busy;
    int busy_cnt = 0;
    select_on();
    for (int i = 0; i < 3; i++) pulse(1'b1);
    chk_pos("R2 before store", 9);
    sel_n = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (store_busy) busy_cnt++;
    end
    chk("R6 busy length", busy_cnt, STORE);
    chk_pos("R6 position after store", 9);
  endtask

  task automatic t_busy_ignore;
    select_on();
    pulse(1'b1);
    sel_n = 1'b1; cyc(6);
    chk("R6 busy after store", int'(store_busy), 1);
    sel_n = 1'b0; cyc(4);
    pulse(1'b1); pulse(1'b1);
    chk_pos("R8 steps during busy", 10);
    cyc(STORE + 5);
    chk("R8 busy ended", int'(store_busy), 0);
    pulse(1'b0);
    chk_pos("R8 stale select after busy", 10);
    sel_n = 1'b1; cyc(8);
    chk("R8 stale deselect stores nothing", int'(store_busy), 0);
  endtask

  task automatic t_recall;
    select_on();
    pulse(1'b1); pulse(1'b1);
    dir_up = 1'b1; cyc(4);
    deselect(1'b0);
    chk_pos("R7 live before reset", 13);
    warm_reset();
    chk_pos("R1 recall last stored", 10);
  endtask

  task automatic t_coincident;
    sel_n = 1'b0; step = 1'b0; dir_up = 1'b1; cyc(5);
    chk_pos("R10 edge with select fall", 10);
    step = 1'b1; cyc(4);
    pulse(1'b1);
    chk_pos("R10 session still works", 11);
    sel_n = 1'b1; step = 1'b0; cyc(6);
    chk_pos("R10 edge with select rise", 11);
    chk("R10 rise with step low no store", int'(store_busy), 0);
    step = 1'b1; cyc(4);
    warm_reset();
    chk_pos("R1 store unchanged by coincident case", 10);
  endtask

  initial begin
    t_reset();
    t_unselected();
    t_updown();
    t_saturate();
    t_discard();
    t_store_and_busy();
    t_busy_ignore();
    t_recall();
    t_coincident();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule